// File: doc/BRIEF.md
# CAN Identifier/Mask Acceptance Filter

This block decides, for every received CAN frame header, whether the frame is kept and where it goes. It holds a bank of filters. Each filter is a 32-bit identifier word, a 32-bit mask word, an enable bit and a receive-FIFO selector. The receiver presents the identifier, the IDE and RTR flags and a one-cycle valid strobe. One clock later the block reports accept or reject, the number of the winning filter, the target FIFO and a FIFO write strobe.

Software programs the filters through a plain write port: bank number, identifier word, mask word, enable and FIFO selector. The port takes effect only while the initialisation input is high. The bank array can be split between two controllers. Banks below the split point serve controller 0, and the rest serve controller 1. Each frame carries a controller select, and only that controller's banks are searched.

Top module: `can_accept_filter`

## Requirements
- R1: A standard frame (IDE=0) is turned into the compare word with its 11-bit identifier in bits 31:21, bits 20:3 zero, IDE in bit 2, RTR in bit 1 and bit 0 zero.
- R2: An extended frame (IDE=1) is turned into the compare word with its 29-bit identifier in bits 31:3, IDE in bit 2, RTR in bit 1 and bit 0 zero.
- R3: An enabled, eligible filter matches when ((compare word XOR identifier word) AND mask word) is zero. A mask bit of 1 forces that bit to be equal, and a 0 makes it don't-care.
- R4: A standard filter, whose identifier and mask are programmed only in bits 31:16 with the low half zero, accepts both data frames (RTR=0) and remote frames (RTR=1) with the matching identifier.
- R5: A filter with bit 2 set in both its identifier word and its mask word rejects every standard frame, even when the upper identifier bits agree.
- R6: When several filters match, the lowest-numbered one wins, and its number is reported on res_index.
- R7: When no filter matches, res_accept is 0, res_index and res_fifo are 0, and fifo_wr stays low.
- R8: A disabled filter never matches.
- R9: A frame with frm_ctrl=0 is checked only against banks 0 to SPLIT-1, and a frame with frm_ctrl=1 only against banks SPLIT to NUM_FILT-1 (default SPLIT=14, NUM_FILT=28).
- R10: A configuration write made while cfg_init is low, or to a bank number of NUM_FILT or above, changes no filter.
- R11: res_valid is high exactly in the cycle after each frm_valid cycle, and back-to-back frames give back-to-back results.
- R12: res_fifo gives the FIFO selector programmed into the winning filter. fifo_wr equals res_valid AND res_accept.
- R13: After reset every filter is disabled, and res_valid, res_accept and fifo_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_init | input | 1 | Initialisation mode; configuration writes are taken only while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Bank number to write |
| cfg_id | input | 32 | Identifier word for the bank |
| cfg_mask | input | 32 | Mask word for the bank |
| cfg_en | input | 1 | Enable for the bank |
| cfg_fifo | input | 1 | Receive FIFO selector for the bank |
| frm_valid | input | 1 | Frame header strobe |
| frm_ctrl | input | 1 | Controller that received the frame |
| frm_id | input | 29 | Identifier, right-aligned (11 bits used when standard) |
| frm_ide | input | 1 | Extended-identifier flag |
| frm_rtr | input | 1 | Remote-frame flag |
| res_valid | output | 1 | Result strobe, one cycle after frm_valid |
| res_accept | output | 1 | Frame matched an enabled filter |
| res_index | output | IDX_W | Number of the winning filter |
| res_fifo | output | 1 | Target receive FIFO |
| fifo_wr | output | 1 | Write strobe towards the receive FIFO |

## Verification
The hardest case to reach is a frame that several filters match while the would-be winner is disabled, lies in the other controller's range, or has just been rewritten with cfg_init low. Only the arbitration order then tells a correct design from a broken one. The stimulus sets up overlapping filters: an exact-match filter below a wider prefix filter, and a catch-all filter in the second controller's range. It then toggles enables, switches cfg_init and re-sends the same headers. The result number must move to the next eligible filter, or must stay where it was.

// File: rtl/can_filt_pkg.sv
// Package: shared widths, bit positions and header packing for the
// acceptance filter. Assumes the 32-bit ID/mask compare-word layout.
package can_filt_pkg;
    localparam int WORD_W   = 32;
    localparam int STD_W    = 11;
    localparam int EXT_W    = 29;
    localparam int IDE_POS  = 2;
    localparam int RTR_POS  = 1;

    // Builds the compare word from a received header (R1, R2).
    function automatic logic [WORD_W-1:0] pack_hdr(input logic [EXT_W-1:0] id,
                                                   input logic ide,
                                                   input logic rtr);
        logic [WORD_W-1:0] w;
        if (ide) begin
            w = {id, ide, rtr, 1'b0};
        end else begin
            w = {id[STD_W-1:0], {(EXT_W-STD_W){1'b0}}, ide, rtr, 1'b0};
        end
        return w;
    endfunction
endpackage

// File: rtl/can_filt_bank.sv
// Filter storage: identifier, mask, enable and FIFO selector per bank.
// Assumes writes only count while init mode is high and the bank number
// is in range; all banks reset to disabled with zero words.
module can_filt_bank #(
    parameter int NUM_FILT = 28,
    parameter int IDX_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_init,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [31:0]               cfg_id,
    input  logic [31:0]               cfg_mask,
    input  logic                      cfg_en,
    input  logic                      cfg_fifo,
    output logic [NUM_FILT-1:0][31:0] id_q,
    output logic [NUM_FILT-1:0][31:0] mask_q,
    output logic [NUM_FILT-1:0]       en_q,
    output logic [NUM_FILT-1:0]       fifo_q
);
    logic wr_ok;

    // Qualifies a write by init mode and bank range.
    always_comb begin
        wr_ok = cfg_we && cfg_init && (32'(cfg_idx) < NUM_FILT);
    end

    for (genvar i = 0; i < NUM_FILT; i++) begin : g_bank
        // Holds or updates one filter bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_q[i]   <= '0;
                mask_q[i] <= '0;
                en_q[i]   <= 1'b0;
                fifo_q[i] <= 1'b0;
            end else if (wr_ok && (cfg_idx == IDX_W'(i))) begin
                id_q[i]   <= cfg_id;
                mask_q[i] <= cfg_mask;
                en_q[i]   <= cfg_en;
                fifo_q[i] <= cfg_fifo;
            end
        end
    end

    p_hold_when_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_init |=> ($stable(en_q) && $stable(id_q) && $stable(mask_q) && $stable(fifo_q)));
endmodule

// File: rtl/can_filt_match.sv
// Parallel comparators: one hit bit per bank for the current compare word.
// Assumes bank eligibility comes from the controller split point.
module can_filt_match #(
    parameter int NUM_FILT = 28,
    parameter int SPLIT    = 14
) (
    input  logic [31:0]               hdr_word,
    input  logic                      ctrl,
    input  logic [NUM_FILT-1:0][31:0] id_q,
    input  logic [NUM_FILT-1:0][31:0] mask_q,
    input  logic [NUM_FILT-1:0]       en_q,
    output logic [NUM_FILT-1:0]       hit
);
    for (genvar i = 0; i < NUM_FILT; i++) begin : g_cmp
        localparam bit IN_UPPER = (i >= SPLIT);
        logic eligible;
        logic equal;
        // Decides eligibility and masked equality for bank i.
        always_comb begin
            eligible = (ctrl == IN_UPPER);
            equal    = (((hdr_word ^ id_q[i]) & mask_q[i]) == 32'd0);
            hit[i]   = en_q[i] && eligible && equal;
        end
    end
endmodule

// File: rtl/can_filt_prio.sv
// Lowest-number-wins arbiter over the hit vector. Assumes any number of
// hits; returns a one-hot grant, the winner number and an any-hit flag.
module can_filt_prio #(
    parameter int NUM_FILT = 28,
    parameter int IDX_W    = 5
) (
    input  logic [NUM_FILT-1:0] hit,
    output logic                any,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_FILT-1:0] grant
);
    // Scans from the top so the lowest set bit is the last to win.
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = NUM_FILT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any   = 1'b1;
                idx   = IDX_W'(i);
                grant = NUM_FILT'(1) << i;
            end
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
// Top of the acceptance filter: packs the header, searches the banks of
// the selected controller and registers the verdict one cycle later.
// Assumes frm_valid is a single-cycle strobe per header.
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_FILT = 28,
    parameter int SPLIT    = 14,
    localparam int IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_init,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_id,
    input  logic [31:0]      cfg_mask,
    input  logic             cfg_en,
    input  logic             cfg_fifo,
    input  logic             frm_valid,
    input  logic             frm_ctrl,
    input  logic [28:0]      frm_id,
    input  logic             frm_ide,
    input  logic             frm_rtr,
    output logic             res_valid,
    output logic             res_accept,
    output logic [IDX_W-1:0] res_index,
    output logic             res_fifo,
    output logic             fifo_wr
);
    logic [NUM_FILT-1:0][31:0] id_q;
    logic [NUM_FILT-1:0][31:0] mask_q;
    logic [NUM_FILT-1:0]       en_q;
    logic [NUM_FILT-1:0]       fifo_q;
    logic [NUM_FILT-1:0]       hit;
    logic [NUM_FILT-1:0]       grant;
    logic                      any;
    logic [IDX_W-1:0]          win;
    logic [31:0]               hdr_word;
    logic                      ctrl_q;

    can_filt_bank #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
        .cfg_en(cfg_en), .cfg_fifo(cfg_fifo),
        .id_q(id_q), .mask_q(mask_q), .en_q(en_q), .fifo_q(fifo_q)
    );

    // Forms the compare word for the incoming header.
    always_comb begin
        hdr_word = pack_hdr(frm_id, frm_ide, frm_rtr);
    end

    can_filt_match #(.NUM_FILT(NUM_FILT), .SPLIT(SPLIT)) match_i (
        .hdr_word(hdr_word), .ctrl(frm_ctrl), .id_q(id_q), .mask_q(mask_q),
        .en_q(en_q), .hit(hit)
    );

    can_filt_prio #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) prio_i (
        .hit(hit), .any(any), .idx(win), .grant(grant)
    );

    // Registers the verdict for each presented header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_index  <= '0;
            res_fifo   <= 1'b0;
            ctrl_q     <= 1'b0;
        end else begin
            res_valid  <= frm_valid;
            ctrl_q     <= frm_ctrl;
            if (frm_valid) begin
                res_accept <= any;
                res_index  <= any ? win : '0;
                res_fifo   <= any ? fifo_q[win] : 1'b0;
            end
        end
    end

    // Drives the FIFO write strobe from the registered verdict.
    always_comb begin
        fifo_wr = res_valid && res_accept;
    end

    p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);
    p_write_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (res_valid && res_accept));
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((hit & (grant - NUM_FILT'(1))) == '0));
    p_index_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |->
            (ctrl_q ? (32'(res_index) >= SPLIT) : (32'(res_index) < SPLIT)));
endmodule

// File: tb/can_accept_filter_tb_top.sv
module can_accept_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NF    = 28;
    localparam int SP    = 14;
    localparam int IW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_init = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0, cfg_fifo = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0] cfg_id = '0, cfg_mask = '0;
    logic frm_valid = 1'b0, frm_ctrl = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic res_valid, res_accept, res_fifo, fifo_wr;
    logic [IW-1:0] res_index;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // shadow filter model
    logic [31:0] m_id [NF];
    logic [31:0] m_mask [NF];
    logic m_en [NF];
    logic m_fifo [NF];

    // scoreboard
    logic [IW+1:0] exp_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    can_accept_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
        .cfg_en(cfg_en), .cfg_fifo(cfg_fifo), .frm_valid(frm_valid),
        .frm_ctrl(frm_ctrl), .frm_id(frm_id), .frm_ide(frm_ide),
        .frm_rtr(frm_rtr), .res_valid(res_valid), .res_accept(res_accept),
        .res_index(res_index), .res_fifo(res_fifo), .fifo_wr(fifo_wr)
    );

    function automatic logic [31:0] word_of(logic [28:0] id, logic ide, logic rtr);
        if (ide) return {id, 1'b1, rtr, 1'b0};          // R2 layout
        return {id[10:0], 18'd0, 1'b0, rtr, 1'b0};      // R1 layout
    endfunction

    task automatic cfg_write(int idx, logic [31:0] id, logic [31:0] mask, logic en, logic fifo);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_id = id; cfg_mask = mask;
        cfg_en = en; cfg_fifo = fifo;
        if (cfg_init && idx < NF) begin
            m_id[idx] = id; m_mask[idx] = mask; m_en[idx] = en; m_fifo[idx] = fifo;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] std_f(logic [10:0] id);
        return {id, 21'd0};
    endfunction

    // driver: present header, push expected verdict
    task automatic send(logic ctrl, logic [28:0] id, logic ide, logic rtr, string tag);
        logic [31:0] w;
        logic acc; logic [IW-1:0] ix; logic ff;
        w = word_of(id, ide, rtr);
        acc = 1'b0; ix = '0; ff = 1'b0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (m_en[i] && (ctrl == (i >= SP)) && (((w ^ m_id[i]) & m_mask[i]) == 0)) begin
                acc = 1'b1; ix = IW'(i); ff = m_fifo[i];
            end
        end
        @(negedge clk);
        frm_valid = 1'b1; frm_ctrl = ctrl; frm_id = id; frm_ide = ide; frm_rtr = rtr;
        exp_q.push_back({acc, ix, ff});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    // monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            logic [IW+1:0] e; string t;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R11: result without header, actual res_valid=1 expected 0");
            end else begin
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if ({res_accept, res_index, res_fifo} !== e || fifo_wr !== e[IW+1]) begin
                    fails++;
                    $display("FAIL %s: actual acc=%0b idx=%0d fifo=%0b wr=%0b expected acc=%0b idx=%0d fifo=%0b",
                             t, res_accept, res_index, res_fifo, fifo_wr, e[IW+1], e[IW:1], e[0]);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) begin
            m_id[i] = '0; m_mask[i] = '0; m_en[i] = 1'b0; m_fifo[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0 || fifo_wr !== 1'b0) begin
            fails++;
            $display("FAIL R13: actual valid=%0b acc=%0b wr=%0b expected 0 0 0", res_valid, res_accept, fifo_wr);
        end
        send(1'b0, 29'h123, 1'b0, 1'b0, "R13 all disabled after reset");
        idle();

        cfg_init = 1'b1;
        cfg_write(0, std_f(11'h123), std_f(11'h7FF), 1'b1, 1'b0);
        cfg_write(1, {29'h1ABC0000, 3'b100}, 32'hFFFF_FFFC, 1'b1, 1'b0);
        cfg_write(2, std_f(11'h120), std_f(11'h7F0), 1'b1, 1'b1);
        cfg_write(3, std_f(11'h555), std_f(11'h7FF), 1'b0, 1'b0);
        cfg_write(14, std_f(11'h123), std_f(11'h7FF), 1'b1, 1'b1);
        cfg_write(15, 32'd0, 32'd0, 1'b1, 1'b0);
        cfg_write(31, std_f(11'h555), std_f(11'h7FF), 1'b1, 1'b1);

        send(1'b0, 29'h123, 1'b0, 1'b0, "R1 R6 standard data exact, lowest of f0/f2");
        send(1'b0, 29'h123, 1'b0, 1'b1, "R4 standard remote frame passes");
        send(1'b0, 29'h125, 1'b0, 1'b0, "R3 R12 prefix match f2 fifo1");
        send(1'b0, 29'h1ABC0000, 1'b1, 1'b0, "R2 extended exact match");
        send(1'b0, 29'h1ABC0001, 1'b1, 1'b0, "R3 extended low bit differs");
        send(1'b0, 29'h6AF, 1'b0, 1'b0, "R5 standard frame vs IDE-forced filter");
        send(1'b0, 29'h555, 1'b0, 1'b0, "R8 R7 disabled filter, out-of-range write");
        send(1'b1, 29'h123, 1'b0, 1'b0, "R9 controller 1 own bank");
        send(1'b1, 29'h777, 1'b0, 1'b1, "R9 controller 1 catch-all");
        send(1'b0, 29'h777, 1'b0, 1'b0, "R9 controller 0 cannot see upper banks");
        idle();

        cfg_init = 1'b0;
        cfg_write(3, std_f(11'h555), std_f(11'h7FF), 1'b1, 1'b1);
        send(1'b0, 29'h555, 1'b0, 1'b0, "R10 write ignored outside init");
        idle();

        cfg_init = 1'b1;
        cfg_write(3, std_f(11'h555), std_f(11'h7FF), 1'b1, 1'b1);
        cfg_write(0, std_f(11'h123), std_f(11'h7FF), 1'b0, 1'b0);
        send(1'b0, 29'h555, 1'b0, 1'b0, "R10 R12 write taken in init");
        send(1'b0, 29'h123, 1'b0, 1'b0, "R6 R8 next winner after disable");
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11: actual %0d results missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11: watchdog expired, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule